// File: doc/BRIEF.md
# Bit-Level Pipelined Unsigned Adder

This block adds two unsigned WIDTH-bit operands in a pipeline made only of half adders. The first row adds the operands bit by bit. Each later row is one half adder narrower and adds the carries left by the row above into the sum positions that are still open. Every row is followed by a register rank. After row k, sum bit k can no longer change, so it moves down the pipeline in plain registers until all bits line up at the output.

A new operand pair may enter on every clock cycle. The block returns one sum per cycle, with a carry-out, exactly WIDTH cycles after the pair entered. The carry-out is the OR of the carries from the top half adder of each row, since at most one of those can be set for any one operand pair. A valid flag moves through the pipeline beside the data. Cycles with the input flag low become gaps at the output.

Top module: `pha_adder`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is sampled low, out_valid is 0.
- R2: out_valid equals the in_valid value sampled WIDTH rising edges earlier. In the cycles after reset, before WIDTH edges have passed, out_valid is 0.
- R3: When out_valid is 1, out_sum equals (in_a + in_b) mod 2^WIDTH for the operands sampled together with that valid, WIDTH edges earlier.
- R4: When out_valid is 1, out_carry equals bit WIDTH of the full sum in_a + in_b of the same pair. For any one pair, no more than one row's top half adder produces a carry.
- R5: With in_valid held at 1 on consecutive cycles, a matching result is produced on every consecutive cycle, with no stalls.
- R6: An input cycle with in_valid at 0 produces a cycle with out_valid at 0, whatever in_a and in_b held. It does not disturb the results of the neighbouring valid pairs.
- R7: Carries that travel through every bit position give the correct result. Examples: all-ones plus 1 gives sum 0 with carry 1, and all-ones plus all-ones gives sum all-ones minus 1 with carry 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | WIDTH | First unsigned operand |
| in_b | input | WIDTH | Second unsigned operand |
| out_valid | output | 1 | Result present this cycle |
| out_sum | output | WIDTH | Low WIDTH bits of the sum |
| out_carry | output | 1 | Carry-out of the sum |

## Verification
The hardest case is a carry that starts in bit 0 and has to pass through every row, one position per stage, while other operand pairs fill the stages before and after it. Random operands rarely produce such a chain. The stimulus therefore places directed all-ones operand pairs inside a back-to-back stream, so that a long carry shares the pipeline with unrelated data in the neighbouring stages. A phase with random gaps in the input valid then checks that invalid slots keep their place and do not mix with the valid results around them.

// File: rtl/pha_pkg.sv
package pha_pkg;

    typedef struct packed {
        logic s;
        logic c;
    } ha_out_t;

    function automatic ha_out_t half_add(input logic x, input logic y);
        ha_out_t r;
        r.s = x ^ y;
        r.c = x & y;
        return r;
    endfunction

    // first bit of row k inside the flat vector of all row carries
    function automatic int row_base(input int n, input int k);
        return k * n - (k * (k - 1)) / 2;
    endfunction

    // first bit of stage k inside the flat vector of registered carries
    function automatic int creg_base(input int n, input int k);
        return k * (n - 1) - (k * (k - 1)) / 2;
    endfunction

endpackage

// File: rtl/pha_row.sv
module pha_row #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);
    import pha_pkg::*;

    for (genvar j = 0; j < W; j++) begin : g_ha
        ha_out_t r;
        assign r    = half_add(x[j], y[j]);
        assign s[j] = r.s;
        assign c[j] = r.c;
    end

endmodule

// File: rtl/pha_stage.sv
module pha_stage #(
    parameter int WIDTH = 8,
    parameter int LVL   = 0,
    localparam int ROW  = WIDTH - LVL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v_in,
    input  logic [WIDTH-1:0] sum_in,
    input  logic [ROW-1:0]   add_in,
    input  logic             cout_in,
    output logic             v_q,
    output logic [WIDTH-1:0] sum_q,
    output logic             cout_q,
    output logic [ROW-1:0]   row_carry
);
    logic [ROW-1:0]   row_sum;
    logic [WIDTH-1:0] sum_nxt;

    pha_row #(.W(ROW)) u_row (
        .x (sum_in[WIDTH-1:LVL]),
        .y (add_in),
        .s (row_sum),
        .c (row_carry)
    );

    if (LVL == 0) begin : g_first
        assign sum_nxt = row_sum;
    end else begin : g_later
        assign sum_nxt = {row_sum, sum_in[LVL-1:0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q    <= 1'b0;
            sum_q  <= '0;
            cout_q <= 1'b0;
        end else begin
            v_q    <= v_in;
            sum_q  <= sum_nxt;
            cout_q <= cout_in | row_carry[ROW-1];
        end
    end

endmodule

// File: rtl/pha_adder.sv
module pha_adder #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_sum,
    output logic             out_carry
);
    localparam int RC_W = (WIDTH * (WIDTH + 1)) / 2;
    localparam int CR_W = (WIDTH * (WIDTH - 1)) / 2;

    logic [WIDTH-1:0] v_vec;
    logic [WIDTH-1:0] co_vec;
    logic [WIDTH-1:0] s_arr [WIDTH];
    logic [RC_W-1:0]  row_c;
    logic [CR_W-1:0]  creg;

    for (genvar k = 0; k < WIDTH; k++) begin : g_stg
        localparam int ROW = WIDTH - k;
        localparam int RB  = pha_pkg::row_base(WIDTH, k);
        localparam int CB  = pha_pkg::creg_base(WIDTH, k);

        logic             v_src;
        logic [WIDTH-1:0] s_src;
        logic [ROW-1:0]   a_src;
        logic             c_src;

        if (k == 0) begin : g_head
            assign v_src = in_valid;
            assign s_src = in_a;
            assign a_src = in_b;
            assign c_src = 1'b0;
        end else begin : g_body
            localparam int PCB = pha_pkg::creg_base(WIDTH, k - 1);
            assign v_src = v_vec[k-1];
            assign s_src = s_arr[k-1];
            assign a_src = creg[PCB +: ROW];
            assign c_src = co_vec[k-1];
        end

        pha_stage #(.WIDTH(WIDTH), .LVL(k)) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .v_in      (v_src),
            .sum_in    (s_src),
            .add_in    (a_src),
            .cout_in   (c_src),
            .v_q       (v_vec[k]),
            .sum_q     (s_arr[k]),
            .cout_q    (co_vec[k]),
            .row_carry (row_c[RB +: ROW])
        );

        // carries below the top one move on to the next, narrower row
        if (k < WIDTH - 1) begin : g_creg
            always_ff @(posedge clk) begin
                if (!rst_n) creg[CB +: ROW-1] <= '0;
                else        creg[CB +: ROW-1] <= row_c[RB +: ROW-1];
            end
        end
    end

    assign out_valid = v_vec[WIDTH-1];
    assign out_sum   = s_arr[WIDTH-1];
    assign out_carry = co_vec[WIDTH-1];

endmodule

// File: rtl/pha_adder_chk.sv
module pha_adder_chk #(
    parameter int WIDTH = 8,
    localparam int RC_W = (WIDTH * (WIDTH + 1)) / 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [WIDTH-1:0] in_a,
    input logic [WIDTH-1:0] in_b,
    input logic             out_valid,
    input logic [WIDTH-1:0] out_sum,
    input logic             out_carry,
    input logic [WIDTH-1:0] co_vec,
    input logic [RC_W-1:0]  row_c
);
    logic             hv [WIDTH];
    logic [WIDTH:0]   hs [WIDTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WIDTH; i++) begin
                hv[i] <= 1'b0;
                hs[i] <= '0;
            end
        end else begin
            hv[0] <= in_valid;
            hs[0] <= {1'b0, in_a} + {1'b0, in_b};
            for (int i = 1; i < WIDTH; i++) begin
                hv[i] <= hv[i-1];
                hs[i] <= hs[i-1];
            end
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == hv[WIDTH-1]);

    assert_sum_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_sum == hs[WIDTH-1][WIDTH-1:0]);

    assert_carry_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_carry == hs[WIDTH-1][WIDTH]);

    for (genvar k = 1; k < WIDTH; k++) begin : g_once
        localparam int MSB = pha_pkg::row_base(WIDTH, k) + WIDTH - k - 1;
        assert_single_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !(co_vec[k-1] && row_c[MSB]));
    end

endmodule

bind pha_adder pha_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_sum   (out_sum),
    .out_carry (out_carry),
    .co_vec    (co_vec),
    .row_c     (row_c)
);

// File: tb/pha_adder_bench.sv
`timescale 1ns/1ps
module pha_adder_bench;
    localparam int W = 8;

    typedef struct packed {
        logic       v;
        logic [W:0] s;
    } ent_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         out_valid;
    logic [W-1:0] out_sum;
    logic         out_carry;

    int    errors = 0;
    int    checks = 0;
    int    issued = 0;
    int    seen = 0;
    bit    done = 0;
    string sum_tag = "R3";
    string vld_tag = "R2";
    ent_t  model [$];

    always #5 clk = ~clk;

    pha_adder #(.WIDTH(W)) u_pha_adder (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_sum   (out_sum),
        .out_carry (out_carry)
    );

    // behavioural reference: queue of sampled pairs, WIDTH deep
    always @(posedge clk) begin
        if (!rst_n) begin
            model.delete();
        end else begin
            model.push_back('{v: in_valid, s: {1'b0, in_a} + {1'b0, in_b}});
            if (model.size() > W) void'(model.pop_front());
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            ent_t e;
            e = (model.size() == W) ? model[0] : '0;
            checks++;
            if (out_valid !== e.v) begin
                errors++;
                $display("FAIL %s valid: got %0b expected %0b", vld_tag, out_valid, e.v);
            end
            if (e.v) begin
                seen++;
                checks++;
                if (out_sum !== e.s[W-1:0]) begin
                    errors++;
                    $display("FAIL %s sum: got %0h expected %0h", sum_tag, out_sum, e.s[W-1:0]);
                end
                checks++;
                if (out_carry !== e.s[W]) begin
                    errors++;
                    $display("FAIL R4 carry: got %0b expected %0b", out_carry, e.s[W]);
                end
            end
        end
    end

    task automatic drive(input logic v, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        in_valid = v;
        in_a     = a;
        in_b     = b;
        if (v) issued++;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 valid in reset: got %0b expected 0", out_valid);
        end
        rst_n = 1'b1;

        // directed long carry chains inside a dense stream (R7)
        sum_tag = "R7";
        drive(1, '1, 1);
        drive(1, '1, '1);
        drive(1, 8'h55, 8'hAA);
        drive(1, 8'h80, 8'h80);
        drive(1, 8'h7F, 8'h01);
        drive(1, '0, '0);
        drive(1, 8'hFE, 8'h02);
        drive(1, '1, 1);

        // back-to-back random stream (R3, R5)
        sum_tag = "R3";
        for (int i = 0; i < 1500; i++) drive(1, W'($urandom), W'($urandom));

        // random gaps with junk data on invalid slots (R6)
        vld_tag = "R6";
        for (int i = 0; i < 800; i++) drive(1'($urandom), W'($urandom), W'($urandom));

        drive(0, '1, '1);
        repeat (W + 2) @(negedge clk);
        done = 1;

        checks++;
        if (seen != issued) begin
            errors++;
            $display("FAIL R5 results: got %0d expected %0d", seen, issued);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL R5 watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule